// File: doc/BRIEF.md
# UART Transmit Gating and DTR Controller

This block sits beside a UART transmitter and decides, on every cycle, whether the transmit path may launch its next data character. It also decides whether a pending in-band flow-control character may go out, and which level the active-low DTR pin carries. Software writes a 4-bit control word that holds three fields. The first is a transmit hold. The second is a gate that lets the DSR input stall data. The third is a 2-bit field that assigns a role to the DTR pin.

The DTR pin has four possible roles. It can follow a software modem-control bit. It can act as an automatic receive-side flow-control line, with hysteresis between an upper and a lower receive-level threshold. It can also act as the enable for an external RS485 line driver, in either polarity. In the driver role, DTR is asserted while the transmitter holds data and is released only after the serial line has returned to its idle marking state. A change to the transmit hold never cuts a character short: the new value is kept pending until the shifter is idle or reports that the current character is finished.

Top module: `uart_tx_gate_dtr`

## Requirements
- R1: When the active transmit hold (control bit 0) is 1, `start_ok` is 0. A held transmitter does not block `fc_ok`.
- R2: A written hold value first becomes pending. It reaches the active hold on the first clock edge at which `shift_busy` is 0 or `char_done` is 1. While `shift_busy` is 1 and `char_done` is 0, the active hold keeps its value.
- R3: When the DSR gate (control bit 1) is 1 and `dsr_n` is 1, `start_ok` is 0.
- R4: When the DSR gate is 0, `dsr_n` has no effect on `start_ok`.
- R5: `fc_ok` equals `fc_req` regardless of the hold and DSR state. While `fc_req` is 1, `start_ok` is 0, so the flow-control character goes first.
- R6: In DTR mode 00 (control bits 3:2), `dtr_n` becomes the inverse of `modem_dtr_on` one clock edge after that input changes.
- R7: In DTR mode 01, a flow-stop state is set on the edge at which `rx_level` >= `rx_thr_hi`. `dtr_n` goes to 1 on the following edge.
- R8: In DTR mode 01, the flow-stop state clears only on an edge at which `rx_level` < `rx_thr_lo`, and `dtr_n` goes to 0 one edge later. Levels between the thresholds keep the previous state.
- R9: In DTR mode 10, a driver-enable state is set on an edge at which `tx_empty` is 0. `dtr_n` goes to 0 on the next edge, and is 1 when the enable state is clear.
- R10: In DTR mode 11, `dtr_n` is 1 while the driver-enable state is set and 0 otherwise, with the same timing as R9.
- R11: The driver-enable state clears only on an edge at which both `tx_empty` and `line_idle` are 1.
- R12: After reset, the hold is 0, the DSR gate is 0, the DTR mode is 00, and `dtr_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_data | input | 4 | Control word: bit 0 hold, bit 1 DSR gate, bits 3:2 DTR mode |
| modem_dtr_on | input | 1 | Software DTR request, 1 means assert (pin low) |
| dsr_n | input | 1 | DSR line, active low |
| rx_level | input | LVL_W | Current receive FIFO fill level |
| rx_thr_hi | input | LVL_W | Upper threshold for receive flow control |
| rx_thr_lo | input | LVL_W | Lower threshold for receive flow control |
| tx_empty | input | 1 | Transmit FIFO and shifter both empty |
| line_idle | input | 1 | Serial output is at its idle marking level |
| shift_busy | input | 1 | Shifter is sending a character |
| char_done | input | 1 | One-cycle pulse when a character completes |
| fc_req | input | 1 | Request to send an in-band flow-control character |
| start_ok | output | 1 | Permit to start the next data character |
| fc_ok | output | 1 | Permit to send the flow-control character |
| dtr_n | output | 1 | DTR pin level, active low |

## Verification
On every cycle, the embedded properties check several behaviours:
- the hold and DSR blocking of `start_ok`;
- the priority of flow-control characters;
- that the active hold cannot change while a character is mid-flight;
- the setting and clearing conditions of the flow-stop and driver-enable states;
- that `dtr_n` follows the mode.

Other behaviours need the bench's scenarios, because they depend on multi-cycle stimulus histories:
- that a deferred hold change lands exactly on the `char_done` edge;
- that levels between the thresholds hold the state from either direction;
- that the driver enable stays asserted while `line_idle` lags `tx_empty`.

The bench's behavioural model covers all outputs in every cycle.

// File: rtl/txg_pkg.sv
package txg_pkg;

   typedef enum logic [1:0] {
      DTR_SOFT   = 2'b00,
      DTR_RXFLOW = 2'b01,
      DTR_EN_LO  = 2'b10,
      DTR_EN_HI  = 2'b11
   } dtr_mode_e;

   localparam int unsigned CTRL_W    = 4;
   localparam int unsigned HOLD_POS  = 0;
   localparam int unsigned GATE_POS  = 1;
   localparam int unsigned MODE_LSB  = 2;

   typedef struct packed {
      dtr_mode_e mode;
      logic      dsr_gate;
      logic      hold;
   } ctrl_t;

endpackage

// File: rtl/txg_hold_sync.sv
module txg_hold_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic hold_in,
   input  logic shift_busy,
   input  logic char_done,
   output logic hold_active
);

   logic pend_q;
   logic act_q;
   logic apply;

   assign apply = !shift_busy || char_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         if (wr_en) pend_q <= hold_in;
         if (apply) act_q  <= pend_q;
      end
   end

   assign hold_active = act_q;

   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_busy && !char_done) |=> $stable(hold_active)); // R2

   AST_HOLD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (char_done) |=> (hold_active == $past(pend_q))); // R2

endmodule

// File: rtl/txg_rx_flow.sv
module txg_rx_flow #(
   parameter int unsigned LVL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] thr_hi,
   input  logic [LVL_W-1:0] thr_lo,
   output logic             stop
);

   logic at_hi;
   logic below_lo;
   logic stop_q;

   assign at_hi    = (level >= thr_hi);
   assign below_lo = (level <  thr_lo);

   always_ff @(posedge clk) begin
      if (!rst_n)        stop_q <= 1'b0;
      else if (at_hi)    stop_q <= 1'b1;
      else if (below_lo) stop_q <= 1'b0;
   end

   assign stop = stop_q;

   AST_FLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (level >= thr_hi) |=> stop); // R7

   AST_FLOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (level >= thr_lo && level < thr_hi) |=> (stop == $past(stop))); // R8

endmodule

// File: rtl/txg_rs485_en.sv
module txg_rs485_en (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_empty,
   input  logic line_idle,
   output logic drv_en
);

   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         en_q <= 1'b0;
      else if (!tx_empty) en_q <= 1'b1;
      else if (line_idle) en_q <= 1'b0;
   end

   assign drv_en = en_q;

   AST_EN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_empty) |=> drv_en); // R9

   AST_EN_LINGER: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en && !line_idle) |=> drv_en); // R11

endmodule

// File: rtl/uart_tx_gate_dtr.sv
module uart_tx_gate_dtr
   import txg_pkg::*;
#(
   parameter int unsigned LVL_W           = 7,
   parameter int unsigned DSR_SYNC_STAGES = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ctrl_we,
   input  logic [CTRL_W-1:0]       ctrl_data,
   input  logic                    modem_dtr_on,
   input  logic                    dsr_n,
   input  logic [LVL_W-1:0]        rx_level,
   input  logic [LVL_W-1:0]        rx_thr_hi,
   input  logic [LVL_W-1:0]        rx_thr_lo,
   input  logic                    tx_empty,
   input  logic                    line_idle,
   input  logic                    shift_busy,
   input  logic                    char_done,
   input  logic                    fc_req,
   output logic                    start_ok,
   output logic                    fc_ok,
   output logic                    dtr_n
);

   localparam int unsigned MAX_SYNC = 4;

   generate
      if (LVL_W < 1 || LVL_W > 16) begin : g_bad_lvl
         $error("uart_tx_gate_dtr: LVL_W must be 1..16");
      end
      if (DSR_SYNC_STAGES > MAX_SYNC) begin : g_bad_sync
         $error("uart_tx_gate_dtr: DSR_SYNC_STAGES too large");
      end
   endgenerate

   ctrl_t     ctrl_w;
   logic      gate_q;
   dtr_mode_e mode_q;

   assign ctrl_w = ctrl_t'(ctrl_data);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         mode_q <= DTR_SOFT;
      end else if (ctrl_we) begin
         gate_q <= ctrl_w.dsr_gate;
         mode_q <= ctrl_w.mode;
      end
   end

   // DSR conditioning: direct or through a reset-to-inactive chain
   logic dsr_n_eff;
   generate
      if (DSR_SYNC_STAGES == 0) begin : g_dsr_direct
         assign dsr_n_eff = dsr_n;
      end else begin : g_dsr_sync
         logic [DSR_SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[DSR_SYNC_STAGES-2:0], dsr_n};
         end
         assign dsr_n_eff = chain_q[DSR_SYNC_STAGES-1];
      end
   endgenerate

   logic hold_active;
   logic stop;
   logic drv_en;

   txg_hold_sync u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (ctrl_we),
      .hold_in     (ctrl_w.hold),
      .shift_busy  (shift_busy),
      .char_done   (char_done),
      .hold_active (hold_active)
   );

   txg_rx_flow #(.LVL_W(LVL_W)) u_flow (
      .clk    (clk),
      .rst_n  (rst_n),
      .level  (rx_level),
      .thr_hi (rx_thr_hi),
      .thr_lo (rx_thr_lo),
      .stop   (stop)
   );

   txg_rs485_en u_drv (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_empty  (tx_empty),
      .line_idle (line_idle),
      .drv_en    (drv_en)
   );

   logic dsr_block;
   assign dsr_block = gate_q && dsr_n_eff;

   assign start_ok = !hold_active && !dsr_block && !fc_req;
   assign fc_ok    = fc_req;

   logic dtr_next;
   always_comb begin
      unique case (mode_q)
         DTR_SOFT:   dtr_next = !modem_dtr_on;
         DTR_RXFLOW: dtr_next = stop;
         DTR_EN_LO:  dtr_next = !drv_en;
         DTR_EN_HI:  dtr_next = drv_en;
         default:    dtr_next = 1'b1;
      endcase
   end

   logic dtr_q;
   always_ff @(posedge clk) begin
      if (!rst_n) dtr_q <= 1'b1;
      else        dtr_q <= dtr_next;
   end
   assign dtr_n = dtr_q;

   AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active |-> !start_ok); // R1

   AST_DSR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_q && dsr_n_eff) |-> !start_ok); // R3

   AST_FC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      fc_req |-> (fc_ok && !start_ok)); // R5

   AST_DTR_FLOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == DTR_RXFLOW && stop) |=> dtr_n); // R7

   AST_DTR_EN_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == DTR_EN_LO && drv_en) |=> !dtr_n); // R9

   AST_DTR_EN_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == DTR_EN_HI && drv_en) |=> dtr_n); // R10

endmodule

// File: tb/sim_uart_tx_gate_dtr.sv
module sim_uart_tx_gate_dtr;

   localparam int LW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctrl_we = 1'b0;
   logic [3:0]    ctrl_data = 4'h0;
   logic          modem_dtr_on = 1'b0;
   logic          dsr_n = 1'b0;
   logic [LW-1:0] rx_level = '0;
   logic [LW-1:0] rx_thr_hi = LW'(10);
   logic [LW-1:0] rx_thr_lo = LW'(4);
   logic          tx_empty = 1'b1;
   logic          line_idle = 1'b1;
   logic          shift_busy = 1'b0;
   logic          char_done = 1'b0;
   logic          fc_req = 1'b0;
   logic          start_ok, fc_ok, dtr_n;

   int checks = 0;
   int errors = 0;
   bit run_cmp = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   uart_tx_gate_dtr #(.LVL_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_data(ctrl_data),
      .modem_dtr_on(modem_dtr_on), .dsr_n(dsr_n), .rx_level(rx_level),
      .rx_thr_hi(rx_thr_hi), .rx_thr_lo(rx_thr_lo), .tx_empty(tx_empty),
      .line_idle(line_idle), .shift_busy(shift_busy), .char_done(char_done),
      .fc_req(fc_req), .start_ok(start_ok), .fc_ok(fc_ok), .dtr_n(dtr_n)
   );

   // behavioural reference
   int m_pend, m_act, m_gate, m_mode, m_stop, m_en, m_dtr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = 0; m_act = 0; m_gate = 0; m_mode = 0;
         m_stop = 0; m_en = 0; m_dtr = 1;
      end else begin
         case (m_mode)
            0: m_dtr = modem_dtr_on ? 0 : 1;
            1: m_dtr = m_stop;
            2: m_dtr = m_en ? 0 : 1;
            default: m_dtr = m_en;
         endcase
         if (!shift_busy || char_done) m_act = m_pend;
         if (ctrl_we) begin
            m_pend = ctrl_data[0];
            m_gate = ctrl_data[1];
            m_mode = int'(ctrl_data[3:2]);
         end
         if (int'(rx_level) >= int'(rx_thr_hi))     m_stop = 1;
         else if (int'(rx_level) < int'(rx_thr_lo)) m_stop = 0;
         if (!tx_empty)     m_en = 1;
         else if (line_idle) m_en = 0;
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   always begin
      @(negedge clk);
      #3;
      if (run_cmp) begin
         chk("R1/R3/R5 start_ok vs model", start_ok,
             (m_act == 0) && !(m_gate == 1 && dsr_n) && !fc_req);
         chk("R5 fc_ok vs model", fc_ok, fc_req);
         chk("R6/R7/R9/R10 dtr_n vs model", dtr_n, m_dtr[0]);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] v);
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_data = v;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   initial begin
      #800000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      modem_dtr_on = 1'b1;
      tick(3); #1;
      chk("R12 reset dtr_n", dtr_n, 1'b1);
      chk("R12 reset start_ok", start_ok, 1'b1);
      chk("R12 reset fc_ok", fc_ok, 1'b0);
      modem_dtr_on = 1'b0;
      @(negedge clk); rst_n = 1'b1; run_cmp = 1'b1;
      tick(1); #1;
      chk("R12 mode 00 after reset", dtr_n, 1'b1);

      // R6 software DTR
      tick(1); modem_dtr_on = 1'b1; tick(1); #1;
      chk("R6 dtr follows soft bit on", dtr_n, 1'b0);
      tick(1); modem_dtr_on = 1'b0; tick(1); #1;
      chk("R6 dtr follows soft bit off", dtr_n, 1'b1);

      // R1 hold, flow char still allowed
      wr(4'b0001); tick(1); #1;
      chk("R1 hold blocks start", start_ok, 1'b0);
      fc_req = 1'b1; #1;
      chk("R1 fc passes while held", fc_ok, 1'b1);
      tick(1); fc_req = 1'b0;

      // R2 deferred release
      shift_busy = 1'b1;
      wr(4'b0000); tick(4); #1;
      chk("R2 hold kept while busy", start_ok, 1'b0);
      tick(1); char_done = 1'b1; tick(1); char_done = 1'b0; #1;
      chk("R2 hold released on char_done", start_ok, 1'b1);
      shift_busy = 1'b0;

      // R3 and R4 DSR gating
      wr(4'b0010); dsr_n = 1'b1; #1;
      chk("R3 dsr inactive blocks", start_ok, 1'b0);
      dsr_n = 1'b0; #1;
      chk("R3 dsr active allows", start_ok, 1'b1);
      wr(4'b0000); dsr_n = 1'b1; #1;
      chk("R4 dsr ignored when gate off", start_ok, 1'b1);
      tick(1); dsr_n = 1'b0;

      // R5 flow char first
      fc_req = 1'b1; #1;
      chk("R5 fc_req blocks data", start_ok, 1'b0);
      chk("R5 fc_ok granted", fc_ok, 1'b1);
      tick(1); fc_req = 1'b0;

      // R7 / R8 receive flow
      wr(4'b0100); tick(1); #1;
      chk("R8 flow mode idle active", dtr_n, 1'b0);
      tick(1); rx_level = LW'(12); tick(2); #1;
      chk("R7 above hi forces inactive", dtr_n, 1'b1);
      tick(1); rx_level = LW'(7); tick(3); #1;
      chk("R8 mid level holds inactive", dtr_n, 1'b1);
      tick(1); rx_level = LW'(4); tick(3); #1;
      chk("R8 equal lo still inactive", dtr_n, 1'b1);
      tick(1); rx_level = LW'(3); tick(2); #1;
      chk("R8 below lo reactivates", dtr_n, 1'b0);
      tick(1); rx_level = LW'(9); tick(3); #1;
      chk("R8 mid level holds active", dtr_n, 1'b0);
      tick(1); rx_level = LW'(10); tick(2); #1;
      chk("R7 equal hi forces inactive", dtr_n, 1'b1);
      tick(1); rx_level = LW'(0); tick(2);

      // R9 / R11 active-low driver enable
      wr(4'b1000); tick(1); #1;
      chk("R9 idle enable released", dtr_n, 1'b1);
      tick(1); tx_empty = 1'b0; tick(2); #1;
      chk("R9 busy drives low", dtr_n, 1'b0);
      tick(1); tx_empty = 1'b1; line_idle = 1'b0; tick(3); #1;
      chk("R11 stays until line idle", dtr_n, 1'b0);
      tick(1); line_idle = 1'b1; tick(2); #1;
      chk("R11 released after idle", dtr_n, 1'b1);

      // R10 active-high driver enable
      wr(4'b1100); tick(1); #1;
      chk("R10 idle enable low", dtr_n, 1'b0);
      tick(1); tx_empty = 1'b0; line_idle = 1'b0; tick(2); #1;
      chk("R10 busy drives high", dtr_n, 1'b1);
      tick(1); tx_empty = 1'b1; tick(2); #1;
      chk("R11 high enable lingers", dtr_n, 1'b1);
      tick(1); line_idle = 1'b1; tick(2); #1;
      chk("R10 released after idle", dtr_n, 1'b0);

      tick(2);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule